// File: doc/BRIEF.md
# PLL Configuration Register Bank

This block is a byte-wide register file that holds the setup of a clock-generator PLL. A simple synchronous bus reaches six registers at consecutive offsets. Each bus cycle carries an address, a write strobe, a read strobe, write data and a combinational read-data path. On the core side the block drives the multiplier, VCO range, reference divider, prescaler and VCO power fields, together with the PLL enable, clock select, auto-bandwidth and acquisition controls. It takes lock and acquisition status back from the PLL and raises an interrupt request when the lock state changes.

The registers are cross-coupled.

- The clock select bit can only be set while the PLL is enabled and the VCO range is non-zero.
- The PLL cannot be disabled while the clock select bit is set.
- The programming fields freeze while the PLL is enabled.
- The interrupt logic only operates in auto-bandwidth mode.
- In auto-bandwidth mode the acquisition bit follows the PLL rather than the bus.

A write takes effect on the clock edge at which it is presented. Read data is valid in the same cycle as the address. Reading the control register clears the interrupt flag at the next edge.

Top module: `pllcfg_regbank`

## Requirements
- R1: The registers sit at offsets 0 to 5, in this order: control, bandwidth, multiplier high, multiplier low, VCO range, reference divider. After reset they read 0x20, 0x00, 0x00, 0x40, 0x40 and 0x01.
- R2: Unused bits read as zero:
  - multiplier high bits 7:4 (bits 3:0 are multiplier 11:8);
  - reference divider bits 7:4 (bits 3:0 are the divider);
  - bandwidth bits 4:0 (bit 7 is auto, bit 6 is lock, bit 5 is acquisition).
- R3: While PLL-on (control bit 5) is 1, writes to offsets 2 to 5 are ignored. The prescaler (control bits 3:2) and the VCO power field (control bits 1:0) stay writable.
- R4: Clock select (control bit 4) is held at 0 and ignores writes whenever either of these is true after the write: PLL-on is 0, or the VCO range is 0x00.
- R5: While clock select is 1, PLL-on stays 1 and ignores writes.
- R6: While auto mode is 0, the following hold:
  - interrupt enable (control bit 7) is held at 0 and ignores writes;
  - the interrupt flag (control bit 6) reads 0 and the lock bit reads 0;
  - the interrupt request is 0.
- R7: While auto mode is 0, the acquisition bit is written from bus bit 5. While auto mode is 1, bus writes to it are ignored and it takes the acquisition input one cycle later.
- R8: In auto mode, any change of the lock input sets the interrupt flag at the next edge. A read of offset 0 clears the flag at the following edge.
- R9: The interrupt request equals the interrupt flag ANDed with interrupt enable. It rises one cycle after a lock change.
- R10: The core outputs carry the register fields. The multiplier output is {high[3:0], low}. The PLL-on, clock select, prescaler and VCO power outputs follow their control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (read of offset 0 clears flag) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| lock_in | input | 1 | Lock status from PLL |
| acq_in | input | 1 | Acquisition status from PLL |
| mul_o | output | 12 | Multiplier |
| vrs_o | output | 8 | VCO range |
| rds_o | output | 4 | Reference divider |
| pre_o | output | 2 | Prescaler |
| vpr_o | output | 2 | VCO power-of-two range |
| pll_on_o | output | 1 | PLL enable |
| bcs_o | output | 1 | Clock select |
| auto_o | output | 1 | Auto-bandwidth mode |
| acq_o | output | 1 | Acquisition mode |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is combinational, so each read is sampled one time step after the address is driven at the falling edge, before the edge that commits the read. A write is visible on the outputs and the read path from the falling edge that follows its rising edge. A lock change driven at a falling edge shows as a raised interrupt request at the next falling edge. The flag clear caused by a read is checked with a second read one cycle later. The acquisition follow-through in auto mode is checked one full cycle after the acquisition input changes.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int MUL_W  = 12;
    localparam int VRS_W  = 8;
    localparam int RDS_W  = 4;
    localparam int MULH_W = MUL_W - DATA_W;

    localparam logic [ADDR_W-1:0] OFF_CTL  = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_BW   = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_MULH = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_MULL = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_VRS  = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_RDS  = 3'd5;

    localparam logic [MUL_W-1:0] MUL_RST = 12'h040;
    localparam logic [VRS_W-1:0] VRS_RST = 8'h40;
    localparam logic [RDS_W-1:0] RDS_RST = 4'h1;

    typedef struct packed {
        logic       ie;
        logic       pll_on;
        logic       bcs;
        logic [1:0] pre;
        logic [1:0] vpr;
    } ctrl_t;

    typedef struct packed {
        logic [MUL_W-1:0] mul;
        logic [VRS_W-1:0] vrs;
        logic [RDS_W-1:0] rds;
    } prog_t;

    localparam ctrl_t CTRL_RST = '{ie: 1'b0, pll_on: 1'b1, bcs: 1'b0, pre: 2'b00, vpr: 2'b00};
    localparam prog_t PROG_RST = '{mul: MUL_RST, vrs: VRS_RST, rds: RDS_RST};

    function automatic logic [DATA_W-1:0] ctrl_byte(ctrl_t c, logic flag);
        return {c.ie, flag, c.pll_on, c.bcs, c.pre, c.vpr};
    endfunction
endpackage

// File: rtl/pllcfg_prog.sv
module pllcfg_prog
    import pllcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              frozen,
    output prog_t             prog
);
    prog_t prog_q, prog_d;
    logic  wr_ok;

    assign wr_ok = wr_en && !frozen;

    always_comb begin
        prog_d = prog_q;
        if (wr_ok) begin
            case (addr)
                OFF_MULH: prog_d.mul[MUL_W-1:DATA_W] = wdata[MULH_W-1:0];
                OFF_MULL: prog_d.mul[DATA_W-1:0]     = wdata;
                OFF_VRS:  prog_d.vrs                 = wdata[VRS_W-1:0];
                OFF_RDS:  prog_d.rds                 = wdata[RDS_W-1:0];
                default:  prog_d = prog_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prog_q <= PROG_RST;
        else     prog_q <= prog_d;
    end

    assign prog = prog_q;
endmodule

// File: rtl/pllcfg_ctrl.sv
module pllcfg_ctrl
    import pllcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              vrs_zero,
    input  logic              lock_in,
    input  logic              acq_in,
    output ctrl_t             ctrl,
    output logic              auto_mode,
    output logic              acq,
    output logic              flag
);
    ctrl_t ctrl_q, ctrl_d;
    logic  auto_q, auto_d;
    logic  acq_q, acq_d;
    logic  flag_q, flag_d;
    logic  lock_q;
    logic  wr_ctl, wr_bw, rd_ctl, lock_chg;
    logic  unused_wbit;

    assign unused_wbit = wdata[6];
    assign wr_ctl   = wr_en && (addr == OFF_CTL);
    assign wr_bw    = wr_en && (addr == OFF_BW);
    assign rd_ctl   = rd_en && (addr == OFF_CTL);
    assign lock_chg = lock_in ^ lock_q;

    always_comb begin
        auto_d = wr_bw ? wdata[7] : auto_q;

        ctrl_d = ctrl_q;
        if (wr_ctl) begin
            ctrl_d.pre = wdata[3:2];
            ctrl_d.vpr = wdata[1:0];
        end

        if (ctrl_q.bcs)  ctrl_d.pll_on = 1'b1;
        else if (wr_ctl) ctrl_d.pll_on = wdata[5];

        if (!ctrl_d.pll_on || vrs_zero) ctrl_d.bcs = 1'b0;
        else if (wr_ctl)                ctrl_d.bcs = wdata[4];

        if (!auto_d)     ctrl_d.ie = 1'b0;
        else if (wr_ctl) ctrl_d.ie = wdata[7];

        if (auto_q)     acq_d = acq_in;
        else if (wr_bw) acq_d = wdata[5];
        else            acq_d = acq_q;

        if (!auto_d)                flag_d = 1'b0;
        else if (auto_q && lock_chg) flag_d = 1'b1;
        else if (rd_ctl)            flag_d = 1'b0;
        else                        flag_d = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            auto_q <= 1'b0;
            acq_q  <= 1'b0;
            flag_q <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            auto_q <= auto_d;
            acq_q  <= acq_d;
            flag_q <= flag_d;
            lock_q <= lock_in;
        end
    end

    assign ctrl      = ctrl_q;
    assign auto_mode = auto_q;
    assign acq       = acq_q;
    assign flag      = flag_q;
endmodule

// File: rtl/pllcfg_rdmux.sv
module pllcfg_rdmux
    import pllcfg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_t             ctrl,
    input  prog_t             prog,
    input  logic              auto_mode,
    input  logic              acq,
    input  logic              flag,
    input  logic              lock_in,
    output logic [DATA_W-1:0] rdata
);
    localparam int MULH_PAD = DATA_W - MULH_W;
    localparam int RDS_PAD  = DATA_W - RDS_W;

    always_comb begin
        case (addr)
            OFF_CTL:  rdata = ctrl_byte(ctrl, flag && auto_mode);
            OFF_BW:   rdata = {auto_mode, lock_in && auto_mode, acq, 5'b0};
            OFF_MULH: rdata = {{MULH_PAD{1'b0}}, prog.mul[MUL_W-1:DATA_W]};
            OFF_MULL: rdata = prog.mul[DATA_W-1:0];
            OFF_VRS:  rdata = prog.vrs;
            OFF_RDS:  rdata = {{RDS_PAD{1'b0}}, prog.rds};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pllcfg_regbank.sv
module pllcfg_regbank
    import pllcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              lock_in,
    input  logic              acq_in,
    output logic [MUL_W-1:0]  mul_o,
    output logic [VRS_W-1:0]  vrs_o,
    output logic [RDS_W-1:0]  rds_o,
    output logic [1:0]        pre_o,
    output logic [1:0]        vpr_o,
    output logic              pll_on_o,
    output logic              bcs_o,
    output logic              auto_o,
    output logic              acq_o,
    output logic              irq_o
);
    ctrl_t ctrl;
    prog_t prog;
    logic  auto_mode, acq, flag;

    pllcfg_prog prog_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .frozen(ctrl.pll_on), .prog(prog)
    );

    pllcfg_ctrl ctrl_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .vrs_zero(prog.vrs == '0), .lock_in(lock_in),
        .acq_in(acq_in), .ctrl(ctrl), .auto_mode(auto_mode), .acq(acq),
        .flag(flag)
    );

    pllcfg_rdmux rdmux_i (
        .addr(addr), .ctrl(ctrl), .prog(prog), .auto_mode(auto_mode),
        .acq(acq), .flag(flag), .lock_in(lock_in), .rdata(rdata)
    );

    assign mul_o    = prog.mul;
    assign vrs_o    = prog.vrs;
    assign rds_o    = prog.rds;
    assign pre_o    = ctrl.pre;
    assign vpr_o    = ctrl.vpr;
    assign pll_on_o = ctrl.pll_on;
    assign bcs_o    = ctrl.bcs;
    assign auto_o   = auto_mode;
    assign acq_o    = acq;
    assign irq_o    = flag && ctrl.ie;
endmodule

// File: rtl/pllcfg_chk.sv
module pllcfg_chk
    import pllcfg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             acq_in,
    input logic [MUL_W-1:0] mul_o,
    input logic [VRS_W-1:0] vrs_o,
    input logic [RDS_W-1:0] rds_o,
    input logic             pll_on_o,
    input logic             bcs_o,
    input logic             auto_o,
    input logic             acq_o,
    input logic             irq_o
);
    // R3
    prog_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        pll_on_o |=> ($stable(mul_o) && $stable(vrs_o) && $stable(rds_o)));

    // R4
    bcs_needs_vrs_chk: assert property (@(posedge clk) disable iff (rst)
        bcs_o |-> (vrs_o != '0));

    // R5
    bcs_keeps_on_chk: assert property (@(posedge clk) disable iff (rst)
        bcs_o |-> pll_on_o);

    // R6
    manual_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        !auto_o |-> !irq_o);

    // R7
    acq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        auto_o |=> (acq_o == $past(acq_in)));
endmodule

bind pllcfg_regbank pllcfg_chk chk_i (
    .clk(clk), .rst(rst), .acq_in(acq_in), .mul_o(mul_o), .vrs_o(vrs_o),
    .rds_o(rds_o), .pll_on_o(pll_on_o), .bcs_o(bcs_o), .auto_o(auto_o),
    .acq_o(acq_o), .irq_o(irq_o)
);

// File: tb/pllcfg_regbank_tb_top.sv
module pllcfg_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        lock_in = 1'b0;
    logic        acq_in = 1'b0;
    logic [11:0] mul_o;
    logic [7:0]  vrs_o;
    logic [3:0]  rds_o;
    logic [1:0]  pre_o, vpr_o;
    logic        pll_on_o, bcs_o, auto_o, acq_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pllcfg_regbank dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .lock_in(lock_in), .acq_in(acq_in),
        .mul_o(mul_o), .vrs_o(vrs_o), .rds_o(rds_o), .pre_o(pre_o),
        .vpr_o(vpr_o), .pll_on_o(pll_on_o), .bcs_o(bcs_o), .auto_o(auto_o),
        .acq_o(acq_o), .irq_o(irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [2:0] a, logic [7:0] exp);
        addr = a; rd_en = 1'b1;
        #1;
        check(req, {24'b0, rdata}, {24'b0, exp});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl reset", 3'd0, 8'h20);
        rd_chk("R1 bw reset", 3'd1, 8'h00);
        rd_chk("R1 mulh reset", 3'd2, 8'h00);
        rd_chk("R1 mull reset", 3'd3, 8'h40);
        rd_chk("R1 vrs reset", 3'd4, 8'h40);
        rd_chk("R1 rds reset", 3'd5, 8'h01);
        check("R10 pll_on reset", {31'b0, pll_on_o}, 32'd1);
        check("R10 mul reset", {20'b0, mul_o}, 32'h040);
    endtask

    task automatic t_prog_lock;
        wr(3'd3, 8'hAA);
        wr(3'd4, 8'h11);
        rd_chk("R3 mull frozen", 3'd3, 8'h40);
        rd_chk("R3 vrs frozen", 3'd4, 8'h40);
        wr(3'd0, 8'h00);
        rd_chk("R3 pll off", 3'd0, 8'h00);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'h5A);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'hF3);
        rd_chk("R2 mulh upper zero", 3'd2, 8'h0F);
        rd_chk("R3 mull written", 3'd3, 8'h5A);
        rd_chk("R2 rds upper zero", 3'd5, 8'h03);
        check("R10 mul_o", {20'b0, mul_o}, 32'hF5A);
        check("R10 rds_o", {28'b0, rds_o}, 32'h3);
    endtask

    task automatic t_bcs;
        wr(3'd0, 8'h10);
        rd_chk("R4 bcs with pll off", 3'd0, 8'h00);
        wr(3'd0, 8'h30);
        rd_chk("R4 bcs with vrs zero", 3'd0, 8'h20);
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h80);
        wr(3'd0, 8'h30);
        rd_chk("R4 bcs set", 3'd0, 8'h30);
        check("R10 bcs_o", {31'b0, bcs_o}, 32'd1);
        wr(3'd0, 8'h0F);
        rd_chk("R5 pll held on", 3'd0, 8'h2F);
        check("R3 pre writable", {30'b0, pre_o}, 32'd3);
        check("R10 vpr_o", {30'b0, vpr_o}, 32'd3);
        wr(3'd4, 8'h00);
        rd_chk("R3 vrs frozen while on", 3'd4, 8'h80);
        wr(3'd0, 8'h00);
        rd_chk("R5 pll off after bcs clear", 3'd0, 8'h00);
    endtask

    task automatic t_manual;
        wr(3'd0, 8'h80);
        rd_chk("R6 ie held clear", 3'd0, 8'h00);
        lock_in = 1'b1;
        @(negedge clk);
        rd_chk("R6 lock reads zero", 3'd1, 8'h00);
        rd_chk("R6 flag reads zero", 3'd0, 8'h00);
        check("R6 irq low", {31'b0, irq_o}, 32'd0);
        wr(3'd1, 8'h3F);
        rd_chk("R7 acq manual write", 3'd1, 8'h20);
        check("R7 acq_o", {31'b0, acq_o}, 32'd1);
        wr(3'd1, 8'h00);
        rd_chk("R7 acq manual clear", 3'd1, 8'h00);
    endtask

    task automatic t_auto_acq;
        acq_in = 1'b0;
        wr(3'd1, 8'h80);
        @(negedge clk);
        rd_chk("R7 auto lock visible", 3'd1, 8'hC0);
        wr(3'd1, 8'hA0);
        rd_chk("R7 acq write ignored", 3'd1, 8'hC0);
        acq_in = 1'b1;
        @(negedge clk);
        rd_chk("R7 acq follows input", 3'd1, 8'hE0);
        acq_in = 1'b0;
        @(negedge clk);
        check("R7 acq_o follows low", {31'b0, acq_o}, 32'd0);
    endtask

    task automatic t_irq;
        wr(3'd0, 8'h80);
        rd_chk("R6 ie set in auto", 3'd0, 8'h80);
        check("R9 irq idle", {31'b0, irq_o}, 32'd0);
        lock_in = 1'b0;
        @(negedge clk);
        check("R9 irq on lock fall", {31'b0, irq_o}, 32'd1);
        rd_chk("R8 flag set", 3'd0, 8'hC0);
        check("R8 flag cleared by read", {31'b0, irq_o}, 32'd0);
        rd_chk("R8 flag reads clear", 3'd0, 8'h80);
        lock_in = 1'b1;
        @(negedge clk);
        check("R8 flag on lock rise", {31'b0, irq_o}, 32'd1);
        lock_in = 1'b0;
        rd_chk("R8 set wins over read", 3'd0, 8'hC0);
        check("R8 flag kept", {31'b0, irq_o}, 32'd1);
        rd_chk("R8 second read", 3'd0, 8'hC0);
        rd_chk("R8 cleared", 3'd0, 8'h80);
    endtask

    task automatic t_auto_off;
        wr(3'd1, 8'h00);
        rd_chk("R6 ie cleared on manual", 3'd0, 8'h00);
        lock_in = 1'b1;
        @(negedge clk);
        check("R6 no irq in manual", {31'b0, irq_o}, 32'd0);
        rd_chk("R6 flag zero in manual", 3'd0, 8'h00);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                t_reset();
                t_prog_lock();
                t_bcs();
                t_manual();
                t_auto_acq();
                t_irq();
                t_auto_off();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule